// File: doc/BRIEF.md
# SHA-512 Two-Round Sigma0/Majority Unit

This datapath unit performs the second half of a SHA-512 hash update across two back-to-back rounds in one operation. It takes three 128-bit operands: an accumulator W, which is also the destination, a second operand X and a third operand Y. It returns a single 128-bit value built from the big Sigma0 rotation function, the bitwise majority function and 64-bit additions that wrap modulo 2^64. The upper 64-bit lane is computed first. The lower lane then depends on it, so the two rounds form a serial chain inside the unit.

Alongside the data, the unit decodes a 32-bit instruction word. It flags whether the word is the update-part-2 encoding and extracts the three 5-bit register indices. The result, the match flag and the indices are captured by one valid-qualified pipeline register. They appear one clock after the input valid and hold while no new valid arrives.

Top module: `sha512_m2_unit`

## Requirements
- R1: Let S(v) be the XOR of v rotated right by 28, by 34 and by 39 bit positions, and let M(a,b,c) be (a&b)^(a&c)^(b&c). Then result_o[127:64] equals M(x[63:0], y[127:64], y[63:0]) + S(y[63:0]) + w[127:64], taken modulo 2^64.
- R2: Let H be the value of result_o[127:64]. Then result_o[63:0] equals M(H, y[63:0], y[127:64]) + S(H) + w[63:0], taken modulo 2^64.
- R3: Both lane sums discard carries out of bit 63. With every operand bit set, the upper lane is 64'hFFFFFFFFFFFFFFFD.
- R4: match_o is 1 exactly when insn_i[31:21] equals 11'b11001110011 and insn_i[15:10] equals 6'b100001. Flipping any one of those 17 bits gives 0.
- R5: rm_o takes insn_i[20:16], rn_o takes insn_i[9:5] and rd_o takes insn_i[4:0], whether or not the word matches.
- R6: valid_o equals valid_i from the previous clock. When valid_i is high, result_o, match_o and the indices show that cycle's inputs after the next rising edge.
- R7: While valid_i is low, result_o, match_o and the indices keep their values, whatever the data and instruction inputs do.
- R8: Asserting rst_ni low clears valid_o, result_o, match_o and the indices to zero without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs are valid this cycle |
| insn_i | input | 32 | Instruction word to decode |
| w_i | input | 128 | Accumulator operand W |
| x_i | input | 128 | Second operand X |
| y_i | input | 128 | Third operand Y |
| valid_o | output | 1 | Registered valid |
| match_o | output | 1 | Registered encoding match flag |
| rm_o | output | 5 | Registered third-operand index |
| rn_o | output | 5 | Registered second-operand index |
| rd_o | output | 5 | Registered destination index |
| result_o | output | 128 | Registered 128-bit result |

## Verification
The hardest case to reach from the ports is the lower lane being driven by a carried-out upper sum. A wrong second-round input only shows up when H differs from every raw operand half, and a lost wrap only shows up when the additions overflow. The stimulus therefore uses all-ones operands, which force a triple overflow in both lanes, and many random operand sets whose upper sums rarely equal any input half. The decode side gets one word per fixed bit, each differing from the match pattern in that bit alone.

// File: rtl/sha512_m2_pkg.sv
package sha512_m2_pkg;
  localparam int unsigned LANE_W = 64;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned INSN_W = 32;

  typedef struct packed {
    logic             match;
    logic [IDX_W-1:0] rm;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rd;
  } dec_t;
endpackage

// File: rtl/sha512_m2_decode.sv
module sha512_m2_decode
  import sha512_m2_pkg::*;
#(
  parameter logic [10:0] OPC_HI  = 11'b11001110011,
  parameter logic [5:0]  OPC_MID = 6'b100001
) (
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);
  localparam int unsigned RD_LSB = 0;
  localparam int unsigned RN_LSB = RD_LSB + IDX_W;
  localparam int unsigned MID_LSB = RN_LSB + IDX_W;
  localparam int unsigned RM_LSB = MID_LSB + $bits(OPC_MID);
  localparam int unsigned HI_LSB = RM_LSB + IDX_W;

  always_comb begin
    dec_o.match = (insn_i[HI_LSB +: $bits(OPC_HI)] == OPC_HI) &&
                  (insn_i[MID_LSB +: $bits(OPC_MID)] == OPC_MID);
    dec_o.rm    = insn_i[RM_LSB +: IDX_W];
    dec_o.rn    = insn_i[RN_LSB +: IDX_W];
    dec_o.rd    = insn_i[RD_LSB +: IDX_W];
  end
endmodule

// File: rtl/sha512_m2_sigma.sv
module sha512_m2_sigma #(
  parameter int unsigned W    = 64,
  parameter int unsigned ROT0 = 28,
  parameter int unsigned ROT1 = 34,
  parameter int unsigned ROT2 = 39
) (
  input  logic [W-1:0] v_i,
  output logic [W-1:0] s_o
);
  localparam int unsigned N_ROT = 3;
  localparam int unsigned ROTS [N_ROT] = '{ROT0, ROT1, ROT2};

  logic [2*W-1:0] dbl;
  logic [W-1:0]   term [N_ROT];

  assign dbl = {v_i, v_i};

  for (genvar k = 0; k < N_ROT; k++) begin : g_rot
    assign term[k] = dbl[ROTS[k] +: W];
  end

  always_comb begin
    s_o = '0;
    for (int k = 0; k < N_ROT; k++) s_o ^= term[k];
  end
endmodule

// File: rtl/sha512_m2_round.sv
module sha512_m2_round #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] maj_a_i,
  input  logic [W-1:0] maj_b_i,
  input  logic [W-1:0] maj_c_i,
  input  logic [W-1:0] sig_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] maj;
  logic [W-1:0] sig;

  assign maj = (maj_a_i & maj_b_i) ^ (maj_a_i & maj_c_i) ^ (maj_b_i & maj_c_i);

  sha512_m2_sigma #(.W(W)) u_sigma (
    .v_i (sig_i),
    .s_o (sig)
  );

  // modular sum: carry out of the lane is dropped
  assign sum_o = maj + sig + add_i;
endmodule

// File: rtl/sha512_m2_unit.sv
module sha512_m2_unit
  import sha512_m2_pkg::*;
#(
  parameter int unsigned LW = LANE_W,
  localparam int unsigned DW = 2 * LW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [DW-1:0]     w_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     y_i,
  output logic              valid_o,
  output logic              match_o,
  output logic [IDX_W-1:0]  rm_o,
  output logic [IDX_W-1:0]  rn_o,
  output logic [IDX_W-1:0]  rd_o,
  output logic [DW-1:0]     result_o
);
  logic [LW-1:0] y_lo, y_hi, hi_sum, lo_sum;
  dec_t          dec;
  dec_t          dec_q;

  assign y_lo = y_i[LW-1:0];
  assign y_hi = y_i[DW-1:LW];

  sha512_m2_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  // first round -> upper lane
  sha512_m2_round #(.W(LW)) u_rnd_hi (
    .maj_a_i (x_i[LW-1:0]),
    .maj_b_i (y_hi),
    .maj_c_i (y_lo),
    .sig_i   (y_lo),
    .add_i   (w_i[DW-1:LW]),
    .sum_o   (hi_sum)
  );

  // second round chains on the fresh upper lane
  sha512_m2_round #(.W(LW)) u_rnd_lo (
    .maj_a_i (hi_sum),
    .maj_b_i (y_lo),
    .maj_c_i (y_hi),
    .sig_i   (hi_sum),
    .add_i   (w_i[LW-1:0]),
    .sum_o   (lo_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      dec_q    <= '0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dec_q    <= dec;
        result_o <= {hi_sum, lo_sum};
      end
    end
  end

  assign match_o = dec_q.match;
  assign rm_o    = dec_q.rm;
  assign rn_o    = dec_q.rn;
  assign rd_o    = dec_q.rd;
endmodule

// File: rtl/sha512_m2_unit_chk.sv
module sha512_m2_unit_chk #(
  parameter int unsigned DW = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [31:0]   insn_i,
  input logic          valid_o,
  input logic          match_o,
  input logic [4:0]    rm_o,
  input logic [4:0]    rn_o,
  input logic [4:0]    rd_o,
  input logic [DW-1:0] result_o
);
  p_valid_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(match_o) &&
                  $stable(rm_o) && $stable(rn_o) && $stable(rd_o)));

  p_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (match_o == (($past(insn_i[31:21]) == 11'b11001110011) &&
                             ($past(insn_i[15:10]) == 6'b100001))));

  p_index_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (rm_o == $past(insn_i[20:16]) && rn_o == $past(insn_i[9:5]) &&
                 rd_o == $past(insn_i[4:0])));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r8: assert (!valid_o && !match_o && result_o == '0);
    end
  end
endmodule

bind sha512_m2_unit sha512_m2_unit_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .insn_i   (insn_i),
  .valid_o  (valid_o),
  .match_o  (match_o),
  .rm_o     (rm_o),
  .rn_o     (rn_o),
  .rd_o     (rd_o),
  .result_o (result_o)
);

// File: tb/sha512_m2_unit_tb_top.sv
module sha512_m2_unit_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         valid_i = 1'b0;
  logic [31:0]  insn_i = '0;
  logic [127:0] w_i = '0, x_i = '0, y_i = '0;
  logic         valid_o, match_o;
  logic [4:0]   rm_o, rn_o, rd_o;
  logic [127:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  logic         e_valid = 0, e_match = 0;
  logic [4:0]   e_rm = 0, e_rn = 0, e_rd = 0;
  logic [127:0] e_res = 0;

  always #10 clk_i = ~clk_i;

  sha512_m2_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .insn_i, .w_i, .x_i, .y_i,
    .valid_o, .match_o, .rm_o, .rn_o, .rd_o, .result_o
  );

  function automatic logic [63:0] ror(input logic [63:0] v, input int n);
    return (v >> n) | (v << (64 - n));
  endfunction
  function automatic logic [63:0] sig0(input logic [63:0] v);
    return ror(v, 28) ^ ror(v, 34) ^ ror(v, 39);
  endfunction
  function automatic logic [63:0] maj(input logic [63:0] a, b, c);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
    return r;
  endfunction
  function automatic logic [127:0] ref_calc(input logic [127:0] w, x, y);
    logic [63:0] h, l;
    h = maj(x[63:0], y[127:64], y[63:0]) + sig0(y[63:0]) + w[127:64];
    l = maj(h, y[63:0], y[127:64]) + sig0(h) + w[63:0];
    return {h, l};
  endfunction
  function automatic logic [31:0] mk_insn(input logic [4:0] rm, rn, rd);
    return {11'b11001110011, rm, 6'b100001, rn, rd};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string rtag);
    check("R6 valid", {127'd0, valid_o}, {127'd0, e_valid});
    check({rtag, " R1 upper"}, {64'd0, result_o[127:64]}, {64'd0, e_res[127:64]});
    check({rtag, " R2 lower"}, {64'd0, result_o[63:0]}, {64'd0, e_res[63:0]});
    check({rtag, " R4 match"}, {127'd0, match_o}, {127'd0, e_match});
    check({rtag, " R5 idx"}, {113'd0, rm_o, rn_o, rd_o}, {113'd0, e_rm, e_rn, e_rd});
  endtask

  // drive at negedge, compare at the negedge after the capturing edge
  task automatic step(input logic v, input logic [31:0] ins,
                      input logic [127:0] w, x, y, input string rtag);
    valid_i = v; insn_i = ins; w_i = w; x_i = x; y_i = y;
    e_valid = v;
    if (v) begin
      e_res   = ref_calc(w, x, y);
      e_match = (ins[31:21] == 11'b11001110011) && (ins[15:10] == 6'b100001);
      e_rm = ins[20:16]; e_rn = ins[9:5]; e_rd = ins[4:0];
    end
    @(posedge clk_i);
    @(negedge clk_i);
    check_all(rtag);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog R6 act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] ones;
    ones = '1;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check_all("R8 reset");
    rst_ni = 1'b1;

    // zeros with a matching word
    step(1, mk_insn(5'd3, 5'd17, 5'd30), '0, '0, '0, "zero");
    // all ones: triple overflow in both lanes
    step(1, mk_insn(5'd31, 5'd0, 5'd31), ones, ones, ones, "R3 ones");
    check("R3 wrap", {64'd0, result_o[127:64]}, {64'd0, 64'hFFFF_FFFF_FFFF_FFFD});

    // random operands
    for (int i = 0; i < 40; i++) begin
      step(1, mk_insn(5'($urandom), 5'($urandom), 5'($urandom)),
           {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, "rand");
    end

    // hold: valid low with changed inputs (R7)
    for (int i = 0; i < 4; i++) begin
      step(0, 32'($urandom), {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R7 hold");
    end

    // single-bit flips of every fixed opcode bit (R4)
    for (int b = 10; b < 32; b++) begin
      if (b < 16 || b > 20) begin
        step(1, mk_insn(5'd9, 5'd4, 5'd22) ^ (32'd1 << b),
             {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R4 flip");
      end
    end

    // async reset mid-run (R8)
    step(1, mk_insn(5'd1, 5'd2, 5'd3), {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "pre");
    rst_ni = 1'b0;
    #2;
    e_valid = 0; e_match = 0; e_res = '0; e_rm = 0; e_rn = 0; e_rd = 0;
    check_all("R8 async");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1, mk_insn(5'd7, 5'd8, 5'd9), ones, '0, ones, "post");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule